// File: doc/BRIEF.md
# Branch Outcome Forwarding Queue

This block sits between two cores that run the same program redundantly, one running ahead of the other. Each time the leading core retires a branch, it writes the branch address, the direction and, as an option, the target into a ring of entries. When the trailing core decodes a branch, it presents that branch's address. The block then searches the stored entries, oldest first. The oldest entry whose address matches supplies the prediction, and that entry and everything older are removed. If no entry matches, the trailing core's own local guess is passed through, and the whole ring is cleared so that it can line up again with later retirements.

When the trailing core resolves a branch, it reports the prediction it used and the real outcome. A difference shows up as an ordinary mispredict pulse. It is never treated as an error, because comparing results is done elsewhere, at commit. A rollback clears the ring. When the ring is full, new retirements are dropped and the leading core is never stalled. Three saturating counters record forwarded hits, fallbacks and mispredicts.

Top module: `branch_fwd_queue`

## Requirements
- R1: After reset the ring holds no entries, all three counters read 0, and a lookup falls back to the local guess.
- R2: A push that is not dropped appends an entry at the tail, so entries are matched in the order the leading core retired them.
- R3: A lookup whose address matches a stored entry raises `pred_hit` in the same cycle. It returns that entry's direction (1 = taken) and, when targets are stored, its target. The oldest matching entry and all entries older than it are then removed.
- R4: A lookup with no matching entry, including a lookup of an empty ring, gives `pred_hit`=0 and `pred_taken` equal to `local_pred_taken`. All stored entries are then discarded.
- R5: A push that arrives while the ring holds DEPTH entries raises `push_dropped` and is not stored. The entries already stored stay unchanged.
- R6: `flush` leaves the ring empty after the edge. A push in the same cycle is dropped, and `push_dropped` reports it.
- R7: `mispredict` is high exactly when `resolve_valid` is high and `resolve_pred_taken` differs from `resolve_taken`, whichever source gave the prediction. Resolving leaves the ring unchanged.
- R8: `hit_count` counts lookups with a hit, `fallback_count` counts lookups without one, and `mispredict_count` counts mispredicts. Each counter updates at the edge after its event and stops at its all-ones value.
- R9: A lookup sees only entries stored before its cycle. A push and a lookup of the same address in one cycle therefore miss, and the pushed entry survives the discard.
- R10: When a lookup misses, `pred_target` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Rollback: clear all entries |
| push_valid | input | 1 | Leading core retired a branch |
| push_pc | input | PC_W | Address of the retired branch |
| push_taken | input | 1 | Direction of the retired branch |
| push_target | input | TGT_W | Target of the retired branch |
| push_dropped | output | 1 | Push discarded (ring full or flush) |
| lookup_valid | input | 1 | Trailing core decodes a branch |
| lookup_pc | input | PC_W | Address of the decoded branch |
| local_pred_taken | input | 1 | Trailing core's own direction guess |
| pred_hit | output | 1 | Prediction came from the ring |
| pred_taken | output | 1 | Direction to use |
| pred_target | output | TGT_W | Forwarded target, 0 on a miss |
| resolve_valid | input | 1 | Trailing core resolved a branch |
| resolve_pred_taken | input | 1 | Direction that was predicted |
| resolve_taken | input | 1 | Actual direction |
| mispredict | output | 1 | Predicted and actual directions differ |
| hit_count | output | CNT_W | Forwarded-hit events |
| fallback_count | output | CNT_W | Fallback events |
| mispredict_count | output | CNT_W | Mispredict events |

## Verification
Directed traffic covers several cases in turn. A lookup that skips older entries separates oldest-match removal from plain head popping. A lookup of an address that is already gone shows that a miss clears the ring and does not just leave it alone. A push and a lookup of the same address in one cycle show which contents the lookup sees. Filling the ring past its depth, and flushing while a push arrives, show that drops leave the stored entries untouched. After that, long random traffic over a small set of addresses mixes hits, misses, partial skips and rare flushes, and runs long enough for every counter to reach saturation.

// File: rtl/bfq_pkg.sv
package bfq_pkg;
   localparam int EV_HIT  = 0;
   localparam int EV_FALL = 1;
   localparam int EV_MISP = 2;
   localparam int NUM_EV  = 3;
endpackage

// File: rtl/bfq_store.sv
// Circular storage of retired branch outcomes with pointer and occupancy logic.
module bfq_store #(
   parameter int DEPTH      = 64,
   parameter int PC_W       = 32,
   parameter int TGT_W      = 32,
   parameter bit HAS_TARGET = 1'b1,
   localparam int AW        = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push_en,
   input  logic [PC_W-1:0]  push_pc,
   input  logic             push_taken,
   input  logic [TGT_W-1:0] push_target,
   input  logic             pop_en,
   input  logic [AW:0]      pop_num,
   input  logic             drop_all,
   output logic [PC_W-1:0]  pc_arr  [DEPTH],
   output logic             dir_arr [DEPTH],
   output logic [TGT_W-1:0] tgt_arr [DEPTH],
   output logic [AW-1:0]    rd_ptr,
   output logic [AW:0]      count
);
   logic [AW-1:0] wr_ptr;

   always_ff @(posedge clk) begin
      if (push_en) begin
         pc_arr[wr_ptr]  <= push_pc;
         dir_arr[wr_ptr] <= push_taken;
      end
   end

   generate
      if (HAS_TARGET) begin : g_tgt
         always_ff @(posedge clk) begin
            if (push_en) tgt_arr[wr_ptr] <= push_target;
         end
      end else begin : g_no_tgt
         for (genvar g = 0; g < DEPTH; g++) begin : g_zero
            assign tgt_arr[g] = '0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         rd_ptr <= wr_ptr;
         count  <= '0;
      end else begin
         if (push_en) wr_ptr <= wr_ptr + AW'(1);
         if (drop_all) begin
            rd_ptr <= wr_ptr;
            count  <= (AW+1)'(push_en);
         end else if (pop_en) begin
            rd_ptr <= rd_ptr + pop_num[AW-1:0];
            count  <= count - pop_num + (AW+1)'(push_en);
         end else begin
            count  <= count + (AW+1)'(push_en);
         end
      end
   end
endmodule

// File: rtl/bfq_match.sv
// Age-ordered search: finds the oldest stored entry whose address matches.
module bfq_match #(
   parameter int DEPTH = 64,
   parameter int PC_W  = 32,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic [PC_W-1:0] pc_arr [DEPTH],
   input  logic [AW-1:0]   rd_ptr,
   input  logic [AW:0]     count,
   input  logic [PC_W-1:0] lookup_pc,
   output logic            hit,
   output logic [AW-1:0]   hit_idx,
   output logic [AW:0]     hit_num
);
   logic [AW-1:0] pos   [DEPTH];
   logic [DEPTH-1:0] match;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
         assign pos[g]   = rd_ptr + AW'(g);
         assign match[g] = ((AW+1)'(g) < count) && (pc_arr[pos[g]] == lookup_pc);
      end
   endgenerate

   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      hit_num = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit     = 1'b1;
            hit_idx = pos[i];
            hit_num = (AW+1)'(i + 1);
         end
      end
   end
endmodule

// File: rtl/bfq_stats.sv
// Saturating event counters, one per event bit.
module bfq_stats #(
   parameter int CNT_W = 16,
   parameter int N_EV  = bfq_pkg::NUM_EV
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EV-1:0]  ev,
   output logic [CNT_W-1:0] cnt [N_EV]
);
   generate
      for (genvar g = 0; g < N_EV; g++) begin : g_cnt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cnt[g] <= '0;
            else if (ev[g] && (cnt[g] != '1)) cnt[g] <= cnt[g] + CNT_W'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/branch_fwd_queue.sv
module branch_fwd_queue #(
   parameter int DEPTH      = 64,
   parameter int PC_W       = 32,
   parameter int TGT_W      = 32,
   parameter bit HAS_TARGET = 1'b1,
   parameter int CNT_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push_valid,
   input  logic [PC_W-1:0]  push_pc,
   input  logic             push_taken,
   input  logic [TGT_W-1:0] push_target,
   output logic             push_dropped,
   input  logic             lookup_valid,
   input  logic [PC_W-1:0]  lookup_pc,
   input  logic             local_pred_taken,
   output logic             pred_hit,
   output logic             pred_taken,
   output logic [TGT_W-1:0] pred_target,
   input  logic             resolve_valid,
   input  logic             resolve_pred_taken,
   input  logic             resolve_taken,
   output logic             mispredict,
   output logic [CNT_W-1:0] hit_count,
   output logic [CNT_W-1:0] fallback_count,
   output logic [CNT_W-1:0] mispredict_count
);
   import bfq_pkg::*;
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("branch_fwd_queue: DEPTH must be a power of two, at least 2");
      end
      if (PC_W < 1 || TGT_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("branch_fwd_queue: widths must be positive");
      end
   endgenerate

   logic [PC_W-1:0]  pc_arr  [DEPTH];
   logic             dir_arr [DEPTH];
   logic [TGT_W-1:0] tgt_arr [DEPTH];
   logic [AW-1:0]    rd_ptr;
   logic [AW:0]      q_count;
   logic             m_hit;
   logic [AW-1:0]    m_idx;
   logic [AW:0]      m_num;
   logic             push_en;
   logic             pop_en;
   logic             drop_all;
   logic [NUM_EV-1:0] ev;
   logic [CNT_W-1:0] cnt [NUM_EV];

   assign push_dropped = push_valid && (flush || (q_count == (AW+1)'(DEPTH)));
   assign push_en      = push_valid && !push_dropped;

   bfq_match #(.DEPTH(DEPTH), .PC_W(PC_W)) u_match (
      .pc_arr    (pc_arr),
      .rd_ptr    (rd_ptr),
      .count     (q_count),
      .lookup_pc (lookup_pc),
      .hit       (m_hit),
      .hit_idx   (m_idx),
      .hit_num   (m_num)
   );

   assign pred_hit    = lookup_valid && m_hit;
   assign pred_taken  = pred_hit ? dir_arr[m_idx] : local_pred_taken;
   assign pred_target = pred_hit ? tgt_arr[m_idx] : '0;
   assign pop_en      = pred_hit && !flush;
   assign drop_all    = lookup_valid && !m_hit && !flush;

   bfq_store #(
      .DEPTH(DEPTH), .PC_W(PC_W), .TGT_W(TGT_W), .HAS_TARGET(HAS_TARGET)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .push_en     (push_en),
      .push_pc     (push_pc),
      .push_taken  (push_taken),
      .push_target (push_target),
      .pop_en      (pop_en),
      .pop_num     (m_num),
      .drop_all    (drop_all),
      .pc_arr      (pc_arr),
      .dir_arr     (dir_arr),
      .tgt_arr     (tgt_arr),
      .rd_ptr      (rd_ptr),
      .count       (q_count)
   );

   assign mispredict = resolve_valid && (resolve_pred_taken != resolve_taken);

   assign ev[EV_HIT]  = pred_hit;
   assign ev[EV_FALL] = lookup_valid && !m_hit;
   assign ev[EV_MISP] = mispredict;

   bfq_stats #(.CNT_W(CNT_W), .N_EV(NUM_EV)) u_stats (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev),
      .cnt   (cnt)
   );

   assign hit_count        = cnt[EV_HIT];
   assign fallback_count   = cnt[EV_FALL];
   assign mispredict_count = cnt[EV_MISP];
endmodule

// File: rtl/branch_fwd_queue_chk.sv
module branch_fwd_queue_chk #(
   parameter int DEPTH = 64,
   parameter int CNT_W = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             push_valid,
   input logic             push_dropped,
   input logic             lookup_valid,
   input logic             pred_hit,
   input logic             pred_taken,
   input logic             local_pred_taken,
   input logic             resolve_valid,
   input logic             mispredict,
   input logic [AW:0]      q_count,
   input logic [CNT_W-1:0] hit_count,
   input logic [CNT_W-1:0] mispredict_count
);
   // R1: occupancy never exceeds the depth
   a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= (AW+1)'(DEPTH));

   a_r5_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && q_count == (AW+1)'(DEPTH)) |-> push_dropped);

   a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count == (AW+1)'(DEPTH) && !flush && !lookup_valid) |=> q_count == (AW+1)'(DEPTH));

   a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> q_count == '0);

   a_r3_hit_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (lookup_valid && pred_hit && !flush && !(push_valid && !push_dropped))
      |=> q_count < $past(q_count));

   a_r4_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (lookup_valid && !pred_hit && !flush)
      |=> q_count == (AW+1)'($past(push_valid && !push_dropped)));

   a_r4_fallback_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (lookup_valid && !pred_hit) |-> pred_taken == local_pred_taken);

   a_r7_quiet_without_resolve: assert property (@(posedge clk) disable iff (!rst_n)
      !resolve_valid |-> !mispredict);

   a_r8_misp_counted: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |=> mispredict_count != '0);

   a_r8_hit_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> hit_count >= $past(hit_count));
endmodule

bind branch_fwd_queue branch_fwd_queue_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .flush            (flush),
   .push_valid       (push_valid),
   .push_dropped     (push_dropped),
   .lookup_valid     (lookup_valid),
   .pred_hit         (pred_hit),
   .pred_taken       (pred_taken),
   .local_pred_taken (local_pred_taken),
   .resolve_valid    (resolve_valid),
   .mispredict       (mispredict),
   .q_count          (q_count),
   .hit_count        (hit_count),
   .mispredict_count (mispredict_count)
);

// File: tb/test_branch_fwd_queue.sv
`timescale 1ns/1ps
module test_branch_fwd_queue;
   localparam int DEPTH = 64;
   localparam int PC_W  = 32;
   localparam int TGT_W = 32;
   localparam int CNT_W = 6;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 0, push_valid = 0, push_taken = 0, lookup_valid = 0, local_pred_taken = 0;
   logic resolve_valid = 0, resolve_pred_taken = 0, resolve_taken = 0;
   logic [PC_W-1:0]  push_pc = '0, lookup_pc = '0;
   logic [TGT_W-1:0] push_target = '0;
   logic push_dropped, pred_hit, pred_taken, mispredict;
   logic [TGT_W-1:0] pred_target;
   logic [CNT_W-1:0] hit_count, fallback_count, mispredict_count;

   always #4 clk = ~clk;

   branch_fwd_queue #(.DEPTH(DEPTH), .PC_W(PC_W), .TGT_W(TGT_W), .HAS_TARGET(1'b1), .CNT_W(CNT_W))
   i_branch_fwd_queue (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push_valid(push_valid), .push_pc(push_pc), .push_taken(push_taken),
      .push_target(push_target), .push_dropped(push_dropped),
      .lookup_valid(lookup_valid), .lookup_pc(lookup_pc), .local_pred_taken(local_pred_taken),
      .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
      .resolve_valid(resolve_valid), .resolve_pred_taken(resolve_pred_taken),
      .resolve_taken(resolve_taken), .mispredict(mispredict),
      .hit_count(hit_count), .fallback_count(fallback_count), .mispredict_count(mispredict_count)
   );

   typedef struct packed {
      logic [PC_W-1:0]  pc;
      logic             dir;
      logic [TGT_W-1:0] tgt;
   } ent_t;

   ent_t model_q[$];
   int m_hit = 0, m_fall = 0, m_misp = 0;
   int checks = 0, failures = 0;
   bit done = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic fl, input logic pv, input logic [31:0] ppc, input logic pt,
                       input logic [31:0] ptg, input logic lv, input logic [31:0] lpc,
                       input logic lp, input logic rv, input logic rp, input logic rt);
      int idx;
      bit e_drop, e_hit, e_dir, e_misp;
      logic [31:0] e_tgt;
      @(negedge clk);
      flush = fl; push_valid = pv; push_pc = ppc; push_taken = pt; push_target = ptg;
      lookup_valid = lv; lookup_pc = lpc; local_pred_taken = lp;
      resolve_valid = rv; resolve_pred_taken = rp; resolve_taken = rt;
      #1;
      idx = -1;
      if (lv) begin
         for (int i = model_q.size() - 1; i >= 0; i--)
            if (model_q[i].pc == lpc) idx = i;
      end
      e_hit  = (idx >= 0);
      e_dir  = e_hit ? model_q[idx].dir : lp;
      e_tgt  = e_hit ? model_q[idx].tgt : 32'h0;
      e_drop = pv && (fl || model_q.size() == DEPTH);
      e_misp = rv && (rp != rt);
      chk("R3/R4 pred_hit", longint'(pred_hit), longint'(e_hit));
      chk("R3/R4 pred_taken", longint'(pred_taken), longint'(e_dir));
      chk("R3 R10 pred_target", longint'(pred_target), longint'(e_tgt));
      chk("R5/R6 push_dropped", longint'(push_dropped), longint'(e_drop));
      chk("R7 mispredict", longint'(mispredict), longint'(e_misp));
      chk("R8 hit_count", longint'(hit_count), longint'(m_hit));
      chk("R8 fallback_count", longint'(fallback_count), longint'(m_fall));
      chk("R8 mispredict_count", longint'(mispredict_count), longint'(m_misp));
      @(posedge clk);
      if (lv && e_hit && m_hit < CMAX) m_hit++;
      if (lv && !e_hit && m_fall < CMAX) m_fall++;
      if (e_misp && m_misp < CMAX) m_misp++;
      if (fl) model_q.delete();
      else begin
         if (lv) begin
            if (e_hit) for (int i = 0; i <= idx; i++) void'(model_q.pop_front());
            else model_q.delete();
         end
         if (pv && !e_drop) model_q.push_back('{pc: ppc, dir: pt, tgt: ptg});
      end
   endtask

   task automatic push(input logic [31:0] pc, input logic t, input logic [31:0] tg);
      step(0, 1, pc, t, tg, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic look(input logic [31:0] pc, input logic lp);
      step(0, 0, 0, 0, 0, 1, pc, lp, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1 hit_count", longint'(hit_count), 0);
      chk("R1 fallback_count", longint'(fallback_count), 0);
      chk("R1 mispredict_count", longint'(mispredict_count), 0);
      rst_n = 1'b1;
      look(32'h100, 1);                      // R1: empty ring falls back
      // R2 R3: ordered entries, skip-ahead match
      push(32'h100, 1, 32'h200);
      push(32'h104, 0, 32'h300);
      push(32'h108, 1, 32'h400);
      look(32'h104, 1);                      // hit, drops 0x100
      look(32'h100, 0);                      // R4: gone -> miss, clears 0x108
      look(32'h108, 0);                      // R4: now empty
      // R9: same-cycle push and lookup
      step(0, 1, 32'h500, 1, 32'h55, 1, 32'h500, 0, 0, 0, 0);
      look(32'h500, 0);                      // R9: surviving entry hits
      // R5: fill past depth
      for (int i = 0; i < DEPTH + 2; i++) push(32'h1000 + 4 * i, i[0], 32'h9000 + i);
      look(32'h1000 + 4 * (DEPTH - 1), 0);   // last stored entry
      push(32'h1000 + 4 * DEPTH, 1, 32'h1);
      look(32'h1000 + 4 * DEPTH, 0);         // R5: dropped earlier, now present again
      // R6: flush with a concurrent push
      push(32'h700, 1, 32'h70);
      step(1, 1, 32'h704, 1, 32'h71, 0, 0, 0, 0, 0, 0);
      look(32'h700, 0);                      // R6: empty after flush
      // R7: mispredict combinations
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
      // random traffic over a small address set, drives R8 saturation
      for (int n = 0; n < 4000; n++) begin
         step(($urandom % 97) == 0, ($urandom % 3) != 0, 32'h40 + 4 * ($urandom % 6),
              1'($urandom), $urandom, ($urandom % 3) == 0, 32'h40 + 4 * ($urandom % 6),
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end
      // R8: counters have saturated
      @(negedge clk);
      chk("R8 hit saturated", longint'(hit_count), CMAX);
      chk("R8 fallback saturated", longint'(fallback_count), CMAX);
      chk("R8 mispredict saturated", longint'(mispredict_count), CMAX);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule